// File: doc/BRIEF.md
# Write Data Prefetch Assembler with Byte Masking

This block sits between the write-data capture stage of a double-data-rate memory interface and a 4n-prefetch memory core. Every clock it receives two 32-bit data words and two 4-bit byte masks, one pair sampled on the rising strobe edge and one on the falling edge. The two edge samples arrive on separate inputs and are registered on one internal clock. A burst of length 4 spans two clocks. The block gathers the four words of a burst into one 128-bit core word, together with a 16-bit byte-enable vector. It then presents that word to the core with a one-cycle valid pulse, so the core sees at most one word every two clocks.

Capture starts a programmable number of clocks (1, 2 or 3) after the write command. Write commands spaced exactly two clocks apart stream without a gap, and each new burst follows directly behind the one before it. A command whose capture window would begin halfway through a burst in progress is rejected. The block flags that command with a one-cycle error pulse and drops its data.

Top module: `ddr_wr_prefetch`

## Requirements
- R1: While rst_ni is low, core_valid_o and err_o are 0 and core_data_o and core_be_o are all zeros.
- R2: The core word places the first rising-edge word in bits [31:0], the first falling-edge word in [63:32], the second rising-edge word in [95:64] and the second falling-edge word in [127:96].
- R3: core_be_o bit 4*k+b is the inverse of mask lane b of word k, where words are numbered in the same order as in R2. A mask bit of 1 disables that byte.
- R4: Each accepted write yields exactly one core_valid_o pulse, one cycle long. core_valid_o is never high in two consecutive cycles.
- R5: Let a write command be sampled at edge E, with write latency WL = wl_i (a value of 0 acts as 1). The first data pair is sampled at edge E+WL and the second at E+WL+1. core_valid_o is high in the cycle after edge E+WL+1.
- R6: Write commands spaced exactly two clocks apart, with the same WL, are all accepted. Their valid pulses follow two clocks apart.
- R7: A command whose capture would start one clock after an accepted capture start raises err_o for one cycle after that start edge. Its data is dropped and the earlier burst is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wl_i | input | 2 | Write latency in clocks (1..3; 0 acts as 1); held steady while writes are pending |
| wr_cmd_i | input | 1 | Write command, one cycle per burst |
| rise_data_i | input | 32 | Data sampled on the rising strobe edge |
| rise_mask_i | input | 4 | Byte mask for rise_data_i, 1 = masked |
| fall_data_i | input | 32 | Data sampled on the falling strobe edge |
| fall_mask_i | input | 4 | Byte mask for fall_data_i, 1 = masked |
| core_data_o | output | 128 | Assembled core word |
| core_be_o | output | 16 | Byte enables for core_data_o, 1 = write |
| core_valid_o | output | 1 | Core word valid, one cycle |
| err_o | output | 1 | Rejected overlapping write, one cycle |

## Verification
The data, byte enables and valid for a write are due in the cycle after edge E+WL+1. The bench samples them at the falling clock edge of that cycle, once both pairs have been registered. An overlap error is due in the cycle after the rejected start edge E'+WL, which is the same cycle as the earlier burst's valid pulse, and it is checked at that same falling edge. A behavioural model keyed by edge number predicts every cycle's valid, error, word and enables, and the bench compares them at each falling edge. A latency probe counts falling edges from the command to the valid pulse for each WL setting.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_BEAT1 = 1'b1
  } phase_e;
endpackage

// File: rtl/wr_lat_delay.sv
module wr_lat_delay #(
  parameter int unsigned MAX_WL = 3,
  localparam int unsigned WL_W = $clog2(MAX_WL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_i,
  input  logic [WL_W-1:0] wl_i,
  output logic            start_o
);
  logic [MAX_WL:0]      dly;
  logic [2**WL_W-1:0]   taps;
  logic [WL_W-1:0]      wl_eff;

  assign dly[0] = cmd_i;

  for (genvar s = 1; s <= MAX_WL; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly[s] <= 1'b0;
      else         dly[s] <= dly[s-1];
    end
  end

  always_comb begin
    taps = '0;
    taps[MAX_WL:1] = dly[MAX_WL:1];
  end

  // latency 0 is not supported: treat as 1
  assign wl_eff  = (wl_i == '0) ? WL_W'(1) : wl_i;
  assign start_o = taps[wl_eff];
endmodule

// File: rtl/wr_beat_ctrl.sv
module wr_beat_ctrl
  import ddr_wr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cap0_o,
  output logic cap1_o,
  output logic valid_o,
  output logic err_o
);
  phase_e ph_q;

  assign cap0_o = start_i && (ph_q == PH_IDLE);
  assign cap1_o = (ph_q == PH_BEAT1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ph_q    <= cap0_o ? PH_BEAT1 : PH_IDLE;
      valid_o <= cap1_o;
      // start landing on the second beat overlaps the running burst
      err_o   <= start_i && cap1_o;
    end
  end
endmodule

// File: rtl/wr_word_pack.sv
module wr_word_pack #(
  parameter int unsigned DQ_W = 32,
  localparam int unsigned LANES  = DQ_W / 8,
  localparam int unsigned CORE_W = 4 * DQ_W,
  localparam int unsigned BE_W   = 4 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap0_i,
  input  logic              cap1_i,
  input  logic [DQ_W-1:0]   rise_data_i,
  input  logic [LANES-1:0]  rise_mask_i,
  input  logic [DQ_W-1:0]   fall_data_i,
  input  logic [LANES-1:0]  fall_mask_i,
  output logic [CORE_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);
  logic [2*DQ_W-1:0]  b0_data_q;
  logic [2*LANES-1:0] b0_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b0_data_q <= '0;
      b0_mask_q <= '0;
    end else if (cap0_i) begin
      b0_data_q <= {fall_data_i, rise_data_i};
      b0_mask_q <= {fall_mask_i, rise_mask_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      be_o   <= '0;
    end else if (cap1_i) begin
      data_o <= {fall_data_i, rise_data_i, b0_data_q};
      be_o   <= ~{fall_mask_i, rise_mask_i, b0_mask_q};
    end
  end
endmodule

// File: rtl/ddr_wr_prefetch.sv
module ddr_wr_prefetch #(
  parameter int unsigned DQ_W   = 32,
  parameter int unsigned MAX_WL = 3,
  localparam int unsigned LANES  = DQ_W / 8,
  localparam int unsigned CORE_W = 4 * DQ_W,
  localparam int unsigned BE_W   = 4 * LANES,
  localparam int unsigned WL_W   = $clog2(MAX_WL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WL_W-1:0]   wl_i,
  input  logic              wr_cmd_i,
  input  logic [DQ_W-1:0]   rise_data_i,
  input  logic [LANES-1:0]  rise_mask_i,
  input  logic [DQ_W-1:0]   fall_data_i,
  input  logic [LANES-1:0]  fall_mask_i,
  output logic [CORE_W-1:0] core_data_o,
  output logic [BE_W-1:0]   core_be_o,
  output logic              core_valid_o,
  output logic              err_o
);
  logic start, cap0, cap1;

  wr_lat_delay #(.MAX_WL(MAX_WL)) i_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (wr_cmd_i),
    .wl_i    (wl_i),
    .start_o (start)
  );

  wr_beat_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cap0_o  (cap0),
    .cap1_o  (cap1),
    .valid_o (core_valid_o),
    .err_o   (err_o)
  );

  wr_word_pack #(.DQ_W(DQ_W)) i_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap0_i      (cap0),
    .cap1_i      (cap1),
    .rise_data_i (rise_data_i),
    .rise_mask_i (rise_mask_i),
    .fall_data_i (fall_data_i),
    .fall_mask_i (fall_mask_i),
    .data_o      (core_data_o),
    .be_o        (core_be_o)
  );
endmodule

// File: rtl/ddr_wr_prefetch_chk.sv
module ddr_wr_prefetch_chk #(
  parameter int unsigned DQ_W   = 32,
  parameter int unsigned MAX_WL = 3,
  localparam int unsigned LANES  = DQ_W / 8,
  localparam int unsigned CORE_W = 4 * DQ_W,
  localparam int unsigned BE_W   = 4 * LANES,
  localparam int unsigned WL_W   = $clog2(MAX_WL + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WL_W-1:0]   wl_i,
  input logic              wr_cmd_i,
  input logic [DQ_W-1:0]   rise_data_i,
  input logic [LANES-1:0]  rise_mask_i,
  input logic [DQ_W-1:0]   fall_data_i,
  input logic [LANES-1:0]  fall_mask_i,
  input logic [CORE_W-1:0] core_data_o,
  input logic [BE_W-1:0]   core_be_o,
  input logic              core_valid_o,
  input logic              err_o
);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |=> !core_valid_o);

  a_r2_word_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> core_data_o == {$past(fall_data_i), $past(rise_data_i),
                                     $past(fall_data_i, 2), $past(rise_data_i, 2)});

  a_r3_byte_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> core_be_o == ~{$past(fall_mask_i), $past(rise_mask_i),
                                    $past(fall_mask_i, 2), $past(rise_mask_i, 2)});

  a_r5_latency_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> ($past(wr_cmd_i, 3) || $past(wr_cmd_i, 4) || $past(wr_cmd_i, 5)));

  a_r7_dropped_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !core_valid_o);

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!core_valid_o && !err_o && core_be_o == '0);
    end
  end
endmodule

bind ddr_wr_prefetch ddr_wr_prefetch_chk #(.DQ_W(DQ_W), .MAX_WL(MAX_WL)) i_chk (.*);

// File: tb/test_ddr_wr_prefetch.sv
module test_ddr_wr_prefetch;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   wl_i = 2'd1;
  logic         wr_cmd_i = 1'b0;
  logic [31:0]  rise_data_i = '0, fall_data_i = '0;
  logic [3:0]   rise_mask_i = '0, fall_mask_i = '0;
  logic [127:0] core_data_o;
  logic [15:0]  core_be_o;
  logic         core_valid_o, err_o;

  int n_chk = 0, n_fail = 0;
  int valid_seen = 0, err_seen = 0;

  always #10 clk_i = ~clk_i;

  ddr_wr_prefetch i_ddr_wr_prefetch (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: everything keyed by edge number
  int edge_n = 0;
  int last_acc = -10;
  bit start_at[int];
  logic [31:0] rd[int], fd[int];
  logic [3:0]  rm[int], fm[int];
  bit          exp_valid = 0, exp_err = 0;
  logic [127:0] exp_data;
  logic [15:0]  exp_be;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      int wl_e;
      edge_n++;
      rd[edge_n] = rise_data_i; fd[edge_n] = fall_data_i;
      rm[edge_n] = rise_mask_i; fm[edge_n] = fall_mask_i;
      wl_e = (wl_i == 0) ? 1 : int'(wl_i);
      if (wr_cmd_i) start_at[edge_n + wl_e] = 1'b1;
      exp_valid = (last_acc == edge_n - 1);
      if (exp_valid) begin
        exp_data = {fd[edge_n], rd[edge_n], fd[edge_n-1], rd[edge_n-1]};
        exp_be   = ~{fm[edge_n], rm[edge_n], fm[edge_n-1], rm[edge_n-1]};
      end
      exp_err = 1'b0;
      if (start_at.exists(edge_n)) begin
        if (last_acc == edge_n - 1) exp_err = 1'b1;
        else                        last_acc = edge_n;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && edge_n > 0) begin
      check(core_valid_o == exp_valid, "R4 valid", 128'(core_valid_o), 128'(exp_valid));
      check(err_o == exp_err, "R7 err", 128'(err_o), 128'(exp_err));
      if (exp_valid) begin
        check(core_data_o == exp_data, "R2 data", core_data_o, exp_data);
        check(core_be_o == exp_be, "R3 byte enable", 128'(core_be_o), 128'(exp_be));
      end
      if (core_valid_o) valid_seen++;
      if (err_o) err_seen++;
    end
  end

  always @(posedge clk_i) begin
    if (edge_n > 50000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic drive(input bit cmd);
    @(negedge clk_i);
    wr_cmd_i    = cmd;
    rise_data_i = $urandom; fall_data_i = $urandom;
    rise_mask_i = 4'($urandom); fall_mask_i = 4'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  task automatic lat_probe(input logic [1:0] wl);
    int got = -1;
    int wl_e = (wl == 0) ? 1 : int'(wl);
    wl_i = wl;
    idle(2);
    drive(1'b1);
    for (int i = 1; i <= 8; i++) begin
      drive(1'b0);
      if (core_valid_o && got < 0) got = i;
    end
    check(got == wl_e + 2, "R5 latency", 128'(got), 128'(wl_e + 2));
  endtask

  initial begin
    int v0, e0;
    repeat (3) @(negedge clk_i);
    check(!core_valid_o && !err_o && core_data_o == '0 && core_be_o == '0,
          "R1 reset", {core_data_o[111:0], core_be_o}, 128'd0);
    rst_ni = 1'b1;
    idle(2);

    for (int w = 0; w < 4; w++) lat_probe(2'(w));

    // R6 gapless stream
    wl_i = 2'd2; idle(4);
    v0 = valid_seen; e0 = err_seen;
    for (int k = 0; k < 4; k++) begin drive(1'b1); drive(1'b0); end
    idle(8);
    check(valid_seen - v0 == 4 && err_seen == e0, "R6 gapless", 128'(valid_seen - v0), 128'd4);

    // R7 overlap
    wl_i = 2'd1; idle(4);
    v0 = valid_seen; e0 = err_seen;
    drive(1'b1); drive(1'b1); idle(8);
    check(err_seen - e0 == 1, "R7 err count", 128'(err_seen - e0), 128'd1);
    check(valid_seen - v0 == 1, "R7 one burst kept", 128'(valid_seen - v0), 128'd1);

    wl_i = 2'd3; idle(6);
    for (int i = 0; i < 3000; i++) drive(($urandom % 3) == 0);
    idle(8);
    wl_i = 2'd1; idle(4);
    for (int i = 0; i < 2000; i++) drive(($urandom % 2) == 0);
    idle(8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule